// File: doc/BRIEF.md
# Masked Fixed-Priority Vectored Interrupt Controller

This block gathers a bank of interrupt request lines, remembers each request until it is served, and at every instruction boundary decides whether the processor should run its next fetch or enter an interrupt. Requests come from hardware lines, which are caught on their rising edge. The topmost lines can also be raised by the program through a set strobe. A mask register splits the lines into equal groups of consecutive priority levels. Each mask bit can hold back one whole group. Requests that are held back stay pending until the program clears their mask bit.

When the processor signals that an instruction has finished and at least one unmasked request is pending, the controller chooses the request with the lowest index (index 0 is the most urgent). On the next clock edge it presents four things together for one cycle: a take pulse, the address of that interrupt's own vector-table word, the program address captured at the boundary as the return link, and a one-hot acknowledge. The processor reads the vector word and jumps to the address stored in it. At the same edge the served request is removed from the pending set. A new edge on that same line in that same cycle is not lost.

No part of this block moves streamed data, so every pin is a plain control or status signal with no valid/ready pair. The processor must act on the take pulse in the cycle in which it appears.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset no request is pending, every mask bit is 1 (all groups held back), and take and ack are low.
- R2: A 0-to-1 transition on irq_lines[i] makes request i pending. A line that stays high does not raise a second request after it has been served.
- R3: A 1 on sw_set[j] during a clock edge makes request NUM_LINES-SW_LINES+j pending. With the defaults this covers indices 24 to 31.
- R4: Mask bit k = 1 holds back requests with index GROUP_SIZE*k to GROUP_SIZE*k+GROUP_SIZE-1. A held-back request stays pending and is taken once its bit is written to 0. mask_wdata is loaded when mask_we is high.
- R5: When several eligible requests are pending, the one with the lowest index is served first.
- R6: take is high for exactly the cycle after a clock edge at which insn_end was high and an eligible request was pending. take never rises without such an edge.
- R7: While take is high, vec_addr equals VEC_BASE plus the index of the served request.
- R8: While take is high, ret_link equals the pc_in value present at the boundary edge.
- R9: While take is high, ack has exactly bit i set for served index i. ack is zero otherwise. The served request is no longer pending afterward.
- R10: A rising edge on a line at the same clock edge that serves that line's request leaves the request pending.
- R11: A request whose rising edge arrives at the same clock edge as a boundary is not seen at that boundary. It is served at the next boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_LINES | Hardware request lines, caught on rising edge |
| sw_set | input | SW_LINES | Program-driven set strobes for the topmost lines |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | NUM_LINES/GROUP_SIZE | New mask value, 1 holds a group back |
| insn_end | input | 1 | Instruction boundary strobe |
| pc_in | input | ADDR_W | Address of the next instruction at the boundary |
| take | output | 1 | Interrupt entry instead of fetch, one cycle |
| vec_addr | output | ADDR_W | Vector-table word to read for the jump target |
| ret_link | output | ADDR_W | Return address to save |
| ack | output | NUM_LINES | One-hot acknowledge of the served request |

## Verification
The bench builds the block with 32 lines, eight program-set lines, groups of four and 16-bit addresses, and moves the vector base to 0x100 so that a missing base offset shows up in vec_addr. With these values every mask bit has its own group, the software strobes overlap the last two groups, and both the lowest and highest indices can be reached. Directed sequences cover edge placement against boundaries: a request edge landing on a boundary, a re-arrival at the serve edge, and a line held high after service.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  // Index width helper that never returns zero, so a single-entry
  // parameter choice still gets a one-bit field.
  function automatic int clog2_min1(input int value);
    int w;
    w = 1;
    while ((1 << w) < value) w++;
    return w;
  endfunction

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int NUM_LINES = 32,
  parameter int SW_LINES  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic [SW_LINES-1:0]  sw_set,
  input  logic [NUM_LINES-1:0] clr,
  output logic [NUM_LINES-1:0] pending
);
  localparam int SW_BASE = NUM_LINES - SW_LINES;

  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] sw_vec;
  logic [NUM_LINES-1:0] set_vec;

  assign rise    = irq_lines & ~prev_q;
  assign sw_vec  = NUM_LINES'(sw_set) << SW_BASE;
  assign set_vec = rise | sw_vec;

  // A new request on the same edge as its clear wins over the clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= irq_lines;
      pend_q <= (pend_q & ~clr) | set_vec;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
  parameter int NUM_LINES  = 32,
  parameter int GROUP_SIZE = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            mask_we,
  input  logic [NUM_LINES/GROUP_SIZE-1:0] mask_wdata,
  input  logic [NUM_LINES-1:0]            pending,
  output logic [NUM_LINES-1:0]            eligible,
  output logic [NUM_LINES/GROUP_SIZE-1:0] mask_q
);
  localparam int NUM_GROUPS = NUM_LINES / GROUP_SIZE;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= mask_wdata;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign eligible[g*GROUP_SIZE +: GROUP_SIZE] =
      pending[g*GROUP_SIZE +: GROUP_SIZE] & {GROUP_SIZE{~mask_q[g]}};
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = 5
) (
  input  logic [NUM_LINES-1:0] eligible,
  output logic                 any,
  output logic [IDX_W-1:0]     idx,
  output logic [NUM_LINES-1:0] onehot
);
  always_comb begin
    idx    = '0;
    onehot = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        idx    = IDX_W'(i);
        onehot = NUM_LINES'(1) << i;
      end
    end
  end

  assign any = |eligible;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int          NUM_LINES  = 32,
  parameter int          SW_LINES   = 8,
  parameter int          GROUP_SIZE = 4,
  parameter int          ADDR_W     = 16,
  parameter int unsigned VEC_BASE   = 'h20
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_LINES-1:0]            irq_lines,
  input  logic [SW_LINES-1:0]             sw_set,
  input  logic                            mask_we,
  input  logic [NUM_LINES/GROUP_SIZE-1:0] mask_wdata,
  input  logic                            insn_end,
  input  logic [ADDR_W-1:0]               pc_in,
  output logic                            take,
  output logic [ADDR_W-1:0]               vec_addr,
  output logic [ADDR_W-1:0]               ret_link,
  output logic [NUM_LINES-1:0]            ack
);
  localparam int NUM_GROUPS = NUM_LINES / GROUP_SIZE;
  localparam int IDX_W      = clog2_min1(NUM_LINES);

  logic [NUM_LINES-1:0]  pending;
  logic [NUM_LINES-1:0]  eligible;
  logic [NUM_GROUPS-1:0] mask_q;
  logic [NUM_LINES-1:0]  win_oh;
  logic [IDX_W-1:0]      win_idx;
  logic                  win_any;
  logic                  enter;
  logic [NUM_LINES-1:0]  clr;

  irq_req_latch #(.NUM_LINES(NUM_LINES), .SW_LINES(SW_LINES)) u_latch (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .sw_set(sw_set),
    .clr(clr), .pending(pending)
  );

  irq_mask_gate #(.NUM_LINES(NUM_LINES), .GROUP_SIZE(GROUP_SIZE)) u_mask (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .pending(pending), .eligible(eligible), .mask_q(mask_q)
  );

  irq_prio_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_pick (
    .eligible(eligible), .any(win_any), .idx(win_idx), .onehot(win_oh)
  );

  assign enter = insn_end & win_any;
  assign clr   = enter ? win_oh : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take     <= 1'b0;
      vec_addr <= '0;
      ret_link <= '0;
      ack      <= '0;
    end else begin
      take <= enter;
      ack  <= clr;
      if (enter) begin
        vec_addr <= ADDR_W'(VEC_BASE) + ADDR_W'(win_idx);
        ret_link <= pc_in;
      end
    end
  end
endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk #(
  parameter int          NUM_LINES  = 32,
  parameter int          GROUP_SIZE = 4,
  parameter int          ADDR_W     = 16,
  parameter int unsigned VEC_BASE   = 'h20
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            insn_end,
  input logic [ADDR_W-1:0]               pc_in,
  input logic                            take,
  input logic [ADDR_W-1:0]               vec_addr,
  input logic [ADDR_W-1:0]               ret_link,
  input logic [NUM_LINES-1:0]            ack,
  input logic [NUM_LINES/GROUP_SIZE-1:0] mask_q
);
  localparam int NUM_GROUPS = NUM_LINES / GROUP_SIZE;
  localparam int IDX_W      = irq_vec_pkg::clog2_min1(NUM_LINES);
  localparam int GRP_W      = irq_vec_pkg::clog2_min1(NUM_GROUPS);

  logic [ADDR_W-1:0]     offset;
  logic [IDX_W-1:0]      served;
  logic [GRP_W-1:0]      served_grp;
  logic [NUM_GROUPS-1:0] mask_d;

  assign offset     = vec_addr - ADDR_W'(VEC_BASE);
  assign served     = IDX_W'(offset);
  assign served_grp = GRP_W'(served / IDX_W'(GROUP_SIZE));

  always_ff @(posedge clk) begin
    if (!rst_n) mask_d <= '1;
    else        mask_d <= mask_q;
  end

  a_r6_take_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(insn_end));

  a_r7_vector_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (offset < ADDR_W'(NUM_LINES)));

  a_r8_return_link: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (ret_link == $past(pc_in)));

  a_r9_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ($countones(ack) == 1));

  a_r9_ack_matches_vector: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (ack == (NUM_LINES'(1) << served)));

  a_r9_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> (ack == '0));

  a_r4_served_group_open: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !mask_d[served_grp]);
endmodule

bind irq_vector_ctrl irq_vector_chk #(
  .NUM_LINES(NUM_LINES), .GROUP_SIZE(GROUP_SIZE),
  .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .pc_in(pc_in),
  .take(take), .vec_addr(vec_addr), .ret_link(ret_link), .ack(ack),
  .mask_q(mask_q)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int          N    = 32;
  localparam int          SWN  = 8;
  localparam int          GRP  = 4;
  localparam int          AW   = 16;
  localparam int unsigned BASE = 'h100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  lines = '0;
  logic [SWN-1:0] sw = '0;
  logic          mwe = 1'b0;
  logic [7:0]    mwd = '0;
  logic          ie = 1'b0;
  logic [AW-1:0] pc = '0;
  logic          take;
  logic [AW-1:0] vec, ret;
  logic [N-1:0]  ack;

  int n_chk = 0;
  int n_fail = 0;

  always #2ns clk = ~clk;

  irq_vector_ctrl #(.NUM_LINES(N), .SW_LINES(SWN), .GROUP_SIZE(GRP),
                    .ADDR_W(AW), .VEC_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .sw_set(sw),
    .mask_we(mwe), .mask_wdata(mwd), .insn_end(ie), .pc_in(pc),
    .take(take), .vec_addr(vec), .ret_link(ret), .ack(ack)
  );

  typedef struct packed {
    logic [31:0] req;
    logic [7:0]  mask;
    logic        hit;
    logic [4:0]  idx;
  } vec_t;

  // Mask bit k (1 = held back) covers indices 4k..4k+3.
  localparam vec_t VECS [10] = '{
    '{32'h0000_0001, 8'h00, 1'b1, 5'd0},
    '{32'h8000_0000, 8'h00, 1'b1, 5'd31},
    '{32'h0000_0F00, 8'h00, 1'b1, 5'd8},
    '{32'h0000_0F00, 8'h04, 1'b0, 5'd0},
    '{32'h0001_0F00, 8'h04, 1'b1, 5'd16},
    '{32'hFFFF_FFFF, 8'h0F, 1'b1, 5'd16},
    '{32'h0000_0000, 8'h00, 1'b0, 5'd0},
    '{32'h0000_0018, 8'h01, 1'b1, 5'd4},
    '{32'hFFFF_FFFF, 8'hFF, 1'b0, 5'd0},
    '{32'h0010_0000, 8'h00, 1'b1, 5'd20}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; lines = '0; sw = '0; mwe = 1'b0; ie = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_mask(input logic [7:0] m);
    @(negedge clk); mwe = 1'b1; mwd = m;
    @(negedge clk); mwe = 1'b0;
  endtask

  task automatic pulse_lines(input logic [N-1:0] r);
    @(negedge clk); lines = r;
    @(negedge clk); lines = '0;
  endtask

  // Drive one boundary; on return the registered outputs of that edge are visible.
  task automatic boundary(input logic [AW-1:0] p);
    @(negedge clk); ie = 1'b1; pc = p;
    @(negedge clk); ie = 1'b0;
  endtask

  task automatic expect_take(input string req, input int idx, input logic [AW-1:0] p);
    chk({req, " take"}, 64'(take), 64'd1);
    chk({req, " R7 vec"}, 64'(vec), 64'(BASE + idx));
    chk({req, " R8 ret"}, 64'(ret), 64'(p));
    chk({req, " R9 ack"}, 64'(ack), 64'(N'(1) << idx));
  endtask

  task automatic expect_none(input string req);
    chk({req, " take"}, 64'(take), 64'd0);
    chk({req, " ack"}, 64'(ack), 64'd0);
  endtask

  initial begin
    #800us;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    // Table walk: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 10; i++) begin
      vec_t v;
      v = VECS[i];
      do_reset();
      write_mask(v.mask);
      pulse_lines(v.req);
      boundary(AW'(16'h1000 + i));
      if (v.hit) expect_take("R5 table", int'(v.idx), AW'(16'h1000 + i));
      else       expect_none("R4 table");
    end

    // R1: reset state, every group held back
    do_reset();
    @(negedge clk);
    expect_none("R1 after reset");
    pulse_lines(32'h0000_0001);
    boundary(16'h2000);
    expect_none("R1 reset mask");
    write_mask(8'h00);
    boundary(16'h2004);
    expect_take("R1 after unmask", 0, 16'h2004);

    // R6: no boundary, no take
    do_reset();
    write_mask(8'h00);
    pulse_lines(32'h0000_0040);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R6 no boundary", 64'(take), 64'd0);
    end
    boundary(16'h2100);
    expect_take("R6 boundary", 6, 16'h2100);

    // R4: held request kept, taken after unmask
    do_reset();
    write_mask(8'h04);
    pulse_lines(32'h0000_0200);
    boundary(16'h2200);
    expect_none("R4 held back");
    write_mask(8'h00);
    boundary(16'h2204);
    expect_take("R4 released", 9, 16'h2204);

    // R5 + R9: served in order, each only once
    do_reset();
    write_mask(8'h00);
    pulse_lines(32'h0000_0024);
    boundary(16'h2300);
    expect_take("R5 first", 2, 16'h2300);
    boundary(16'h2304);
    expect_take("R5 second", 5, 16'h2304);
    boundary(16'h2308);
    expect_none("R9 drained");

    // R2: held level does not re-request
    do_reset();
    write_mask(8'h00);
    @(negedge clk); lines = 32'h0000_0008;
    boundary(16'h2400);
    expect_take("R2 edge", 3, 16'h2400);
    boundary(16'h2404);
    expect_none("R2 level held");
    @(negedge clk); lines = '0;

    // R3: program-set requests on the top lines
    do_reset();
    write_mask(8'h00);
    @(negedge clk); sw = 8'h05;
    @(negedge clk); sw = '0;
    boundary(16'h2500);
    expect_take("R3 sw 24", 24, 16'h2500);
    boundary(16'h2504);
    expect_take("R3 sw 26", 26, 16'h2504);
    boundary(16'h2508);
    expect_none("R3 sw drained");

    // R10: re-arrival at the serve edge stays pending
    do_reset();
    write_mask(8'h00);
    @(negedge clk); lines = 32'h0000_1000;
    @(negedge clk); lines = '0;
    @(negedge clk); lines = 32'h0000_1000; ie = 1'b1; pc = 16'h2600;
    @(negedge clk); ie = 1'b0; lines = '0;
    expect_take("R10 first", 12, 16'h2600);
    boundary(16'h2604);
    expect_take("R10 again", 12, 16'h2604);

    // R11: edge on the boundary edge is seen one boundary later
    do_reset();
    write_mask(8'h00);
    @(negedge clk); lines = 32'h0002_0000; ie = 1'b1; pc = 16'h2700;
    @(negedge clk); ie = 1'b0; lines = '0;
    expect_none("R11 same edge");
    boundary(16'h2704);
    expect_take("R11 next", 17, 16'h2704);

    summary();
    $finish;
  end
endmodule